// File: doc/BRIEF.md
# Burst Address Sequencer with Wrap

This block steps through the word addresses of a synchronous burst for a 1M x 16 pseudo-static memory whose address and data share one bus. A one-clock `start` pulse captures the first word address, the burst length code, the wrap choice and the continuous choice. From the next clock the block shows one word address at a time on a valid/ready port. A word is consumed on each clock edge where `word_valid` and `word_ready` are both high.

Wrapped fixed-length bursts move around inside the aligned group that holds the start address. Unwrapped and continuous bursts count upward without limit. Each time a linear burst steps onto the first word of a new row, the block pauses for a fixed number of clocks. During the pause it drops `word_valid` and raises `row_stall`, so that the memory side can insert wait states. A fixed-length burst flags its final word with `word_last` and goes idle once that word is consumed. Back-pressure rule: while `word_valid` is high and `word_ready` is low, the address holds. While `word_valid` is low, `word_ready` is ignored.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is held and immediately after it, `word_valid`, `word_last` and `row_stall` are low and `word_addr` is 0.
- R2: A `start` pulse makes `word_valid` high on the next clock with `word_addr` equal to the captured `start_addr`. There is no stall at the first word, even if it sits on a row boundary.
- R3: `blen` selects the defined burst length. 0 gives 4 words, 1 gives 8, 2 gives 16 and 3 gives 32.
- R4: With `wrap_en`=1 and `cont_en`=0, the lower log2(length) address bits step upward modulo the length. The upper bits stay fixed.
- R5: With `wrap_en`=0, or with `cont_en`=1, each consumed word adds one to the full 20-bit address. The address rolls from FFFFFh to 00000h.
- R6: `word_last` is high only while the final word of a defined-length burst is offered. It is never high in continuous mode.
- R7: After the final word of a defined-length burst is consumed, `word_valid` stays low until the next `start`.
- R8: While `word_valid` is high and `word_ready` is low, `word_addr` and `word_valid` hold.
- R9: When a linear burst steps to an address whose low log2(ROW_WORDS) bits are zero, the following STALL_CLKS clocks show `row_stall`=1 and `word_valid`=0. After that, the new address is offered.
- R10: `word_ready` during a stall has no effect: the address and the remaining stall length are unchanged.
- R11: A `start` during an active burst or stall abandons that burst and begins the new one, following R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Captures burst setup on this clock |
| start_addr | input | AW | First word address of the burst |
| blen | input | 2 | Burst length code (R3) |
| wrap_en | input | 1 | Wrap inside the aligned group |
| cont_en | input | 1 | Continuous burst, length ignored |
| word_ready | input | 1 | Consumer takes the offered word |
| word_valid | output | 1 | An address is offered |
| word_addr | output | AW | Offered word address |
| word_last | output | 1 | Offered word is the final one |
| row_stall | output | 1 | Row-boundary wait request |

## Verification
A wrong address register shows up on `word_addr` at the first offered word after the fault. A wrong wrap mask only shows up when the group boundary is reached, so wrapped bursts are started at several offsets in every length. A beat counter that is off by one moves `word_last` and the idle point by one handshake. A stall timer fault stretches or shortens the `row_stall` window, which the checks see on the first boundary crossing.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [1:0] {
    BLEN_4  = 2'd0,
    BLEN_8  = 2'd1,
    BLEN_16 = 2'd2,
    BLEN_32 = 2'd3
  } blen_e;

  localparam int MAX_LOG2 = 5;

  // log2 of the burst length for a code
  function automatic logic [2:0] len_log2(blen_e code);
    return 3'(code) + 3'd2;
  endfunction
endpackage

// File: rtl/burst_next_addr.sv
module burst_next_addr #(
  parameter int AW       = 20,
  parameter int ROW_BITS = 7
) (
  input  logic [AW-1:0] cur,
  input  logic          wrap,
  input  logic [2:0]    lg,
  output logic [AW-1:0] nxt,
  output logic          row_cross
);
  logic [AW-1:0] mask;
  logic [AW-1:0] inc;

  always_comb begin
    mask = (AW'(1) << lg) - AW'(1);
    inc  = cur + AW'(1);
    nxt  = wrap ? ((cur & ~mask) | (inc & mask)) : inc;
  end

  generate
    if (ROW_BITS > 0) begin : g_rows
      assign row_cross = !wrap && (nxt[ROW_BITS-1:0] == '0);
    end else begin : g_norows
      assign row_cross = !wrap;
    end
  endgenerate
endmodule

// File: rtl/burst_stall_timer.sv
module burst_stall_timer #(
  parameter int STALL_CLKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic load,
  output logic busy
);
  localparam int SW = $clog2(STALL_CLKS + 1);
  logic [SW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clear)  cnt <= '0;
    else if (load)        cnt <= SW'(STALL_CLKS);
    else if (cnt != '0)   cnt <= cnt - SW'(1);
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter #(
  parameter int CW = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       inc,
  input  logic       cont,
  input  logic [2:0] lg,
  output logic       at_end
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] lenm1;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt <= '0;
    else if (inc)        cnt <= cnt + CW'(1);
  end

  always_comb begin
    lenm1  = CW'((32'd1 << lg) - 32'd1);
    at_end = !cont && (cnt == lenm1);
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int AW         = 20,
  parameter int ROW_WORDS  = 128,
  parameter int STALL_CLKS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [1:0]    blen,
  input  logic          wrap_en,
  input  logic          cont_en,
  input  logic          word_ready,
  output logic          word_valid,
  output logic [AW-1:0] word_addr,
  output logic          word_last,
  output logic          row_stall
);
  localparam int ROW_BITS = $clog2(ROW_WORDS);

  logic          active_q;
  logic          wrap_q;
  logic          cont_q;
  logic [2:0]    lg_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] nxt_addr;
  logic          row_cross;
  logic          stall_busy;
  logic          beat_end;
  logic          fire;

  assign fire = word_valid && word_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wrap_q   <= 1'b0;
      cont_q   <= 1'b0;
      lg_q     <= 3'd2;
      addr_q   <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      wrap_q   <= wrap_en && !cont_en;
      cont_q   <= cont_en;
      lg_q     <= len_log2(blen_e'(blen));
      addr_q   <= start_addr;
    end else if (fire) begin
      if (word_last) active_q <= 1'b0;
      else           addr_q   <= nxt_addr;
    end
  end

  burst_next_addr #(.AW(AW), .ROW_BITS(ROW_BITS)) u_next (
    .cur(addr_q), .wrap(wrap_q), .lg(lg_q),
    .nxt(nxt_addr), .row_cross(row_cross)
  );

  burst_stall_timer #(.STALL_CLKS(STALL_CLKS)) u_stall (
    .clk(clk), .rst_n(rst_n), .clear(start),
    .load(fire && !word_last && row_cross), .busy(stall_busy)
  );

  burst_beat_counter #(.CW(MAX_LOG2)) u_beats (
    .clk(clk), .rst_n(rst_n), .clear(start), .inc(fire),
    .cont(cont_q), .lg(lg_q), .at_end(beat_end)
  );

  assign word_valid = active_q && !stall_busy;
  assign row_stall  = active_q && stall_busy;
  assign word_last  = word_valid && beat_end;
  assign word_addr  = addr_q;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int AW       = 20,
  parameter int ROW_BITS = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          word_ready,
  input logic          word_valid,
  input logic [AW-1:0] word_addr,
  input logic          word_last,
  input logic          row_stall,
  input logic          wrap_q,
  input logic          cont_q
);
  logic at_row_end;
  assign at_row_end = &word_addr[ROW_BITS-1:0];

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !word_ready && !start |=> word_valid && $stable(word_addr));

  a_r9_stall_excl: assert property (@(posedge clk) disable iff (!rst_n)
    row_stall |-> !word_valid);

  a_r9_stall_entry: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && word_ready && !word_last && !start && !wrap_q && at_row_end
    |=> row_stall);

  a_r5_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && word_ready && !word_last && !start && !wrap_q && !at_row_end
    |=> word_valid && (word_addr == AW'($past(word_addr) + AW'(1))));

  a_r7_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && word_ready && word_last && !start |=> !word_valid && !row_stall);

  a_r6_no_last_cont: assert property (@(posedge clk) disable iff (!rst_n)
    cont_q |-> !word_last);

  a_r10_stall_addr: assert property (@(posedge clk) disable iff (!rst_n)
    row_stall && !start |=> $stable(word_addr));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW), .ROW_BITS(ROW_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .word_ready(word_ready),
  .word_valid(word_valid), .word_addr(word_addr), .word_last(word_last),
  .row_stall(row_stall), .wrap_q(wrap_q), .cont_q(cont_q)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int AW = 20;
  localparam int ROWW = 128;
  localparam int STALLN = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [1:0] blen = '0;
  logic wrap_en = 1'b0, cont_en = 1'b0, word_ready = 1'b0;
  logic word_valid, word_last, row_stall;
  logic [AW-1:0] word_addr;

  int checks = 0, errors = 0;

  // reference state
  bit m_active = 0, m_wrap = 0, m_cont = 0;
  int m_idx = 0, m_stall = 0, m_len = 4;
  logic [AW-1:0] m_start = '0;

  always #5 clk = ~clk;

  burst_addr_seq #(.AW(AW), .ROW_WORDS(ROWW), .STALL_CLKS(STALLN)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .blen(blen), .wrap_en(wrap_en), .cont_en(cont_en), .word_ready(word_ready),
    .word_valid(word_valid), .word_addr(word_addr), .word_last(word_last),
    .row_stall(row_stall)
  );

  function automatic logic [AW-1:0] exp_addr_of(int idx);
    logic [AW-1:0] mask;
    mask = AW'(m_len - 1);
    if (m_wrap) return (m_start & ~mask) | ((m_start + AW'(idx)) & mask);
    return m_start + AW'(idx);
  endfunction

  function automatic bit exp_valid(); return m_active && m_stall == 0; endfunction
  function automatic bit exp_last();
    return exp_valid() && !m_cont && m_idx == m_len - 1;
  endfunction

  task automatic check_now(string tag);
    bit ev, el, es;
    logic [AW-1:0] ea;
    ev = exp_valid(); el = exp_last(); es = m_active && m_stall > 0;
    ea = exp_addr_of(m_idx);
    checks++;
    if (word_valid !== ev || word_last !== el || row_stall !== es ||
        (ev && word_addr !== ea)) begin
      errors++;
      $display("FAIL %s: valid=%0b/%0b addr=%h/%h last=%0b/%0b stall=%0b/%0b (actual/expected)",
               tag, word_valid, ev, word_addr, ea, word_last, el, row_stall, es);
    end
  endtask

  // check, drive one clock of inputs, advance reference, wait a clock
  task automatic step(string tag, bit st, logic [AW-1:0] sa, int bl, bit wr, bit ct, bit rdy);
    bit ev, el;
    check_now(tag);
    start = st; start_addr = sa; blen = 2'(bl); wrap_en = wr; cont_en = ct;
    word_ready = rdy;
    ev = exp_valid(); el = exp_last();
    if (st) begin
      m_active = 1; m_idx = 0; m_stall = 0; m_start = sa;
      m_len = 4 << bl; m_cont = ct; m_wrap = wr && !ct;
    end else if (ev && rdy) begin
      if (el) m_active = 0;
      else begin
        m_idx++;
        if (!m_wrap && (exp_addr_of(m_idx) % ROWW) == 0) m_stall = STALLN;
      end
    end else if (m_stall > 0) m_stall--;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_burst(string tag, logic [AW-1:0] sa, int bl, bit wr, bit ct,
                           int cycles, int rdy_pct);
    step(tag, 1, sa, bl, wr, ct, 0);
    for (int i = 0; i < cycles; i++)
      step(tag, 0, '0, 0, 0, 0, ($urandom % 100) < rdy_pct);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check_now("R1 reset");
    if (word_addr !== '0) begin errors++; $display("FAIL R1: addr=%h expected 0", word_addr); end
    checks++;
    rst_n = 1'b1;
    step("R1 after reset", 0, '0, 0, 0, 0, 1);

    // R2 start at row boundary: no stall on the first word
    run_burst("R2", 20'h00100, 0, 0, 0, 6, 100);
    // R3 and R4: every length, wrapped, non-zero offsets
    for (int bl = 0; bl < 4; bl++) begin
      run_burst("R3", 20'h0A200 | AW'((4 << bl) - 1), bl, 1, 0, (4 << bl) + 3, 100);
      run_burst("R4", 20'h31040 | AW'(1), bl, 1, 0, (4 << bl) + 2, 100);
    end
    // R5 linear crossing a group, and top-of-space rollover
    run_burst("R5", 20'h0005E, 3, 0, 0, 40, 100);
    run_burst("R5 rollover", 20'hFFFFE, 0, 0, 1, 12, 100);
    // R6 continuous: no last flag over many words
    run_burst("R6", 20'h0207A, 2, 1, 1, 60, 100);
    // R7 idle after last, with ready held high
    run_burst("R7", 20'h00010, 1, 0, 0, 14, 100);
    // R8 back-pressure
    run_burst("R8", 20'h12345, 2, 1, 0, 60, 40);
    // R9 row crossing inside a fixed linear burst
    run_burst("R9", 20'h0007C, 1, 0, 0, 16, 100);
    // R10 ready toggling across a stall
    run_burst("R10", 20'h0017E, 0, 0, 1, 14, 50);
    // R11 restart mid-stall and mid-burst
    run_burst("R11", 20'h0027F, 3, 0, 0, 2, 100);
    run_burst("R11", 20'h05555, 0, 1, 0, 2, 100);
    run_burst("R11", 20'h00400, 2, 0, 0, 20, 100);
    // random mix
    for (int n = 0; n < 40; n++)
      run_burst("R5 random", AW'($urandom), int'($urandom % 4), bit'($urandom % 2),
                ($urandom % 4) == 0, 20 + int'($urandom % 60), 50 + int'($urandom % 50));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule